// File: doc/BRIEF.md
# Single-Cycle Integer Register ALU with Test Flag

This block is the execution stage for a small group of single-cycle register operations in a 32-bit processor with 16-bit instructions. Each cycle the issue logic presents an instruction word, the values of the source register (Rm) and the destination register (Rn), and the current test flag T. One clock edge later the block presents the value to be written back to Rn, a write enable, the next value of T, and an illegal-instruction flag.

Seven operations are recognised. They are decrement-with-zero-test, sign extension of a byte or a halfword, zero extension of a byte or a halfword, two's-complement negate, and negate with borrow. The T flag gets a different rule per operation. Decrement loads a zero test into T. Negate-with-borrow loads the borrow out into T. Every other recognised operation passes T through unchanged. Any other instruction word raises the illegal flag and writes nothing. The register file and instruction fetch live outside this block.

Top module: `int_alu_tflag`

## Requirements
- R1: Word `0100_nnnn_0001_0000` writes Rn−1 (mod 2^32) to Rn. T becomes 1 when the result is zero and 0 otherwise, so Rn=0 wraps to 0xFFFFFFFF with T=0.
- R2: Word `0110_nnnn_mmmm_1110` writes Rm[7:0] sign-extended to 32 bits. Word `0110_nnnn_mmmm_1111` writes Rm[15:0] sign-extended.
- R3: Word `0110_nnnn_mmmm_1100` writes Rm[7:0] zero-extended. Word `0110_nnnn_mmmm_1101` writes Rm[15:0] zero-extended.
- R4: Word `0110_nnnn_mmmm_1011` writes 0−Rm. This operation and the four extensions leave T equal to the incoming T.
- R5: Word `0110_nnnn_mmmm_1010` writes 0−Rm−T. T becomes the borrow out, which is 1 exactly when Rm≠0 or the incoming T=1 (Rm=0xFFFFFFFF with T=1 gives result 0 and borrow 1).
- R6: Any other instruction word, when issued, raises `illegal_o` and holds `wr_en_o` low. `t_next_o` then equals the incoming T and `rn_result_o` is 0.
- R7: Results of an instruction issued at one rising edge appear at that edge and are valid for one cycle. In a cycle with no issue, `wr_en_o` and `illegal_o` are 0 and `t_next_o` follows `t_i`.
- R8: While `rst_n` is low at a rising edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 16 | Instruction word |
| rm_val_i | input | 32 | Source register value |
| rn_val_i | input | 32 | Destination register value |
| t_i | input | 1 | Current T flag |
| rn_result_o | output | 32 | Value to write to Rn |
| wr_en_o | output | 1 | Write Rn this cycle |
| t_next_o | output | 1 | Next T flag value |
| illegal_o | output | 1 | Issued word is not a recognised operation |

## Verification
Embedded assertions check, on every cycle, the following properties:
- the T rule of each operation class: zero test, borrow, or pass-through;
- that write enable and the illegal flag are never high together;
- that an idle cycle produces no write and no illegal flag.

Only the bench scenarios show that the written data values are correct. Those scenarios include the extension boundary patterns, decrement wrap, and negate-with-borrow at Rm=0xFFFFFFFF. The bench also sweeps all 65,536 instruction words to show that exactly the seven encodings are accepted.

// File: rtl/int_alu_pkg.sv
// Package: shared operation codes for the single-cycle ALU.
// Assumes a 16-bit instruction word; widths used by the modules are parameters.
package int_alu_pkg;
    typedef enum logic [2:0] {
        OP_DEC  = 3'd0,
        OP_SXB  = 3'd1,
        OP_SXW  = 3'd2,
        OP_ZXB  = 3'd3,
        OP_ZXW  = 3'd4,
        OP_NEG  = 3'd5,
        OP_NEGB = 3'd6,
        OP_BAD  = 3'd7
    } alu_op_e;
endpackage

// File: rtl/int_alu_decode.sv
// Module: int_alu_decode
// Maps a 16-bit instruction word to one of the supported operations or OP_BAD.
// Assumes the major opcode sits in bits [15:12] and the sub-op in the low bits.
module int_alu_decode
    import int_alu_pkg::*;
#(
    parameter int INSN_W = 16
) (
    input  logic [INSN_W-1:0] insn_i,
    output alu_op_e           op_o
);
    localparam int MAJ_LSB = INSN_W - 4;

    logic [3:0] major;
    logic [3:0] sub;
    logic [7:0] low8;

    assign major = insn_i[INSN_W-1:MAJ_LSB];
    assign sub   = insn_i[3:0];
    assign low8  = insn_i[7:0];

    // Classify the instruction word by major group and sub-op field.
    always_comb begin
        op_o = OP_BAD;
        if (major == 4'h4 && low8 == 8'h10) begin
            op_o = OP_DEC;
        end else if (major == 4'h6) begin
            case (sub)
                4'hE:    op_o = OP_SXB;
                4'hF:    op_o = OP_SXW;
                4'hC:    op_o = OP_ZXB;
                4'hD:    op_o = OP_ZXW;
                4'hB:    op_o = OP_NEG;
                4'hA:    op_o = OP_NEGB;
                default: op_o = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/int_alu_datapath.sv
// Module: int_alu_datapath
// Combinational result and next-T computation for one decoded operation.
// Assumes DATA_W >= 16 so byte and halfword extension fields exist.
module int_alu_datapath
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] rm_i,
    input  logic [DATA_W-1:0] rn_i,
    input  logic              t_i,
    output logic [DATA_W-1:0] res_o,
    output logic              t_o
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic [DATA_W-1:0] dec_val;
    logic [DATA_W:0]   negb_full;
    logic [DATA_W-1:0] ext_val [4];

    // Decrement with natural wrap-around.
    assign dec_val   = rn_i - {{(DATA_W-1){1'b0}}, 1'b1};
    // Widened subtraction: the top bit is the borrow out.
    assign negb_full = {(DATA_W+1){1'b0}} - {1'b0, rm_i} - {{DATA_W{1'b0}}, t_i};

    // Extension variants: index bit0 picks halfword, bit1 picks sign.
    for (genvar g = 0; g < 4; g++) begin : g_ext
        localparam int FW = (g % 2 == 1) ? HALF_W : BYTE_W;
        localparam bit SG = (g >= 2);
        assign ext_val[g] = {{(DATA_W-FW){SG ? rm_i[FW-1] : 1'b0}}, rm_i[FW-1:0]};
    end

    // Select result and T update per operation.
    always_comb begin
        res_o = '0;
        t_o   = t_i;
        unique case (op_i)
            OP_DEC: begin
                res_o = dec_val;
                t_o   = (dec_val == '0);
            end
            OP_ZXB:  res_o = ext_val[0];
            OP_ZXW:  res_o = ext_val[1];
            OP_SXB:  res_o = ext_val[2];
            OP_SXW:  res_o = ext_val[3];
            OP_NEG:  res_o = '0 - rm_i;
            OP_NEGB: begin
                res_o = negb_full[DATA_W-1:0];
                t_o   = negb_full[DATA_W];
            end
            default: begin
                res_o = '0;
                t_o   = t_i;
            end
        endcase
    end
endmodule

// File: rtl/int_alu_tflag.sv
// Module: int_alu_tflag (top)
// Decodes an issued instruction, computes its result and T update, and
// registers write-back outputs one edge later. Synchronous active-low reset.
// Assumes the caller holds the operands stable with issue_i for the whole cycle.
module int_alu_tflag
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int INSN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [DATA_W-1:0] rm_val_i,
    input  logic [DATA_W-1:0] rn_val_i,
    input  logic              t_i,
    output logic [DATA_W-1:0] rn_result_o,
    output logic              wr_en_o,
    output logic              t_next_o,
    output logic              illegal_o
);
    alu_op_e           op;
    logic [DATA_W-1:0] res_c;
    logic              t_c;
    logic              op_bad;

    int_alu_decode #(.INSN_W(INSN_W)) u_dec (
        .insn_i (insn_i),
        .op_o   (op)
    );

    int_alu_datapath #(.DATA_W(DATA_W)) u_dp (
        .op_i  (op),
        .rm_i  (rm_val_i),
        .rn_i  (rn_val_i),
        .t_i   (t_i),
        .res_o (res_c),
        .t_o   (t_c)
    );

    assign op_bad = (op == OP_BAD);

    // Register write-back outputs; idle cycles pass T through and write nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rn_result_o <= '0;
            wr_en_o     <= 1'b0;
            t_next_o    <= 1'b0;
            illegal_o   <= 1'b0;
        end else if (issue_i) begin
            rn_result_o <= op_bad ? '0 : res_c;
            wr_en_o     <= !op_bad;
            t_next_o    <= op_bad ? t_i : t_c;
            illegal_o   <= op_bad;
        end else begin
            rn_result_o <= '0;
            wr_en_o     <= 1'b0;
            t_next_o    <= t_i;
            illegal_o   <= 1'b0;
        end
    end

    AST_DEC_ZERO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && op == OP_DEC |=> t_next_o == (rn_result_o == '0)); // R1
    AST_KEEP_T: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && (op == OP_SXB || op == OP_SXW || op == OP_ZXB || op == OP_ZXW || op == OP_NEG)
        |=> t_next_o == $past(t_i)); // R4
    AST_NEGB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && op == OP_NEGB |=> t_next_o == (($past(rm_val_i) != '0) || $past(t_i))); // R5
    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && op == OP_BAD |=> illegal_o && !wr_en_o && t_next_o == $past(t_i)); // R6
    AST_WR_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && illegal_o)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !wr_en_o && !illegal_o && t_next_o == $past(t_i)); // R7
endmodule

// File: tb/tb_int_alu_tflag.sv
`timescale 1ns/1ps
module tb_int_alu_tflag;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [15:0] insn_i = '0;
    logic [31:0] rm_val_i = '0;
    logic [31:0] rn_val_i = '0;
    logic        t_i = 1'b0;
    logic [31:0] rn_result_o;
    logic        wr_en_o, t_next_o, illegal_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    int_alu_tflag dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i),
        .rm_val_i(rm_val_i), .rn_val_i(rn_val_i), .t_i(t_i),
        .rn_result_o(rn_result_o), .wr_en_o(wr_en_o),
        .t_next_o(t_next_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Issue one word at a negedge; sample at the following negedge.
    task automatic run(input string req, input logic [15:0] w, input logic [31:0] rm,
                       input logic [31:0] rn, input logic t,
                       input logic [31:0] e_res, input logic e_wr, input logic e_t,
                       input logic e_ill);
        issue_i = 1'b1; insn_i = w; rm_val_i = rm; rn_val_i = rn; t_i = t;
        @(posedge clk); @(negedge clk);
        chk({req, " result"}, rn_result_o, e_res);
        chk({req, " wr_en"}, {31'b0, wr_en_o}, {31'b0, e_wr});
        chk({req, " t_next"}, {31'b0, t_next_o}, {31'b0, e_t});
        chk({req, " illegal"}, {31'b0, illegal_o}, {31'b0, e_ill});
    endtask

    initial begin
        #(8ns * 200000);
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] pats [12];
        pats = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h7FFF, 32'h8000,
                 32'hFFFF, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'hCAFE_8A9C};
        repeat (3) @(negedge clk);
        // R8: outputs cleared under reset
        chk("R8 result", rn_result_o, 32'h0);
        chk("R8 flags", {29'b0, wr_en_o, t_next_o, illegal_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: decrement with zero test, including wrap
        run("R1 dec 1", 16'h4310, 32'h0, 32'h1, 1'b0, 32'h0, 1, 1, 0);
        run("R1 dec 0 wrap", 16'h4A10, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, 1, 0, 0);
        run("R1 dec 2", 16'h4010, 32'h0, 32'h2, 1'b1, 32'h1, 1, 0, 0);

        for (int p = 0; p < 12; p++) begin
            for (int tv = 0; tv < 2; tv++) begin
                logic [31:0] rm;
                logic        tb;
                logic [32:0] full;
                rm = pats[p];
                tb = tv[0];
                run("R1 dec sweep", 16'h4510, 32'h0, rm, tb, rm - 1, 1, rm == 32'h1, 0);
                run("R2 sext byte", 16'h612E, rm, 32'h5, tb,
                    {{24{rm[7]}}, rm[7:0]}, 1, tb, 0);
                run("R2 sext half", 16'h612F, rm, 32'h5, tb,
                    {{16{rm[15]}}, rm[15:0]}, 1, tb, 0);
                run("R3 zext byte", 16'h634C, rm, 32'h5, tb, {24'h0, rm[7:0]}, 1, tb, 0);
                run("R3 zext half", 16'h634D, rm, 32'h5, tb, {16'h0, rm[15:0]}, 1, tb, 0);
                run("R4 neg", 16'h67FB, rm, 32'h5, tb, 32'h0 - rm, 1, tb, 0);
                full = 33'h0 - {1'b0, rm} - {32'h0, tb};
                run("R5 negc", 16'h698A, rm, 32'h5, tb, full[31:0], 1,
                    (rm != 32'h0) || tb, 0);
            end
        end
        // R5: explicit corner Rm=all-ones with T=1
        run("R5 negc corner", 16'h601A, 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0, 1, 1, 0);

        // R6: sweep every instruction word for legality
        for (int w = 0; w < 65536; w++) begin
            logic [15:0] iw;
            logic        legal;
            iw = w[15:0];
            legal = (iw[15:12] == 4'h4 && iw[7:0] == 8'h10) ||
                    (iw[15:12] == 4'h6 && iw[3:0] >= 4'hA);
            issue_i = 1'b1; insn_i = iw; rm_val_i = 32'h3; rn_val_i = 32'h3; t_i = iw[4];
            @(posedge clk); @(negedge clk);
            if (!legal) begin
                chk("R6 illegal flag", {31'b0, illegal_o}, 32'h1);
                chk("R6 no write", {31'b0, wr_en_o}, 32'h0);
                chk("R6 T kept", {31'b0, t_next_o}, {31'b0, iw[4]});
                chk("R6 result zero", rn_result_o, 32'h0);
            end else begin
                chk("R6 legal accepted", {30'b0, wr_en_o, illegal_o}, 32'h2);
            end
        end

        // R7: idle cycle writes nothing and passes T
        issue_i = 1'b0; insn_i = 16'h4010; t_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 idle wr_en", {31'b0, wr_en_o}, 32'h0);
        chk("R7 idle illegal", {31'b0, illegal_o}, 32'h0);
        chk("R7 idle T", {31'b0, t_next_o}, 32'h1);
        // R7: result lasts one cycle only
        run("R7 single", 16'h6F0C, 32'hAB, 32'h0, 1'b0, 32'hAB, 1, 0, 0);
        issue_i = 1'b0; t_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 drop after one", {31'b0, wr_en_o}, 32'h0);

        // R8: reset mid-run clears outputs
        issue_i = 1'b1; insn_i = 16'h6001; rst_n = 1'b0; t_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R8 mid reset", {rn_result_o[28:0], wr_en_o, t_next_o, illegal_o}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule